// File: doc/BRIEF.md
# Indexed Pixel Palette and Cursor Overlay Stage

This block sits at the end of a display pipeline that carries 8-bit indexed pixels. Each pixel arrives with a valid flag and its raster x/y coordinates. The block turns the index into a 24-bit RGB value through a 256-entry color table. It then overlays a 64x64 hardware cursor whose pixels are 2-bit codes; a non-zero code replaces the table color with one of three cursor colors. Two control inputs are applied per pixel. One suppresses the cursor. The other forces the whole screen to black.

A register block loads the color table, the cursor color table and the cursor shape through a single write port. A select field on that port steers each write to one of the three memories. Pixels enter at full rate and leave two clocks later, with the valid flag carried alongside.

Top module: `pixmix_top`

## Requirements
- R1: Synchronous active-high reset clears `out_valid` to 0, `out_rgb` to 0 and every color-table, cursor-color and cursor-shape entry to 0. A pixel sent after reset with no writes therefore comes out black.
- R2: `out_valid` equals `in_valid` from two clocks earlier. `out_rgb` is 0 whenever `out_valid` is 0.
- R3: A write with `wr_sel`=0 stores `wr_data` into color-table entry `wr_addr[7:0]`. Red is bits 23:16, green bits 15:8 and blue bits 7:0. `out_rgb` uses the same packing. Outside the cursor, a pixel outputs the entry named by `in_index`.
- R4: `cur_pos` carries the cursor x in bits 23:12 and the cursor y in bits 11:0. A pixel lies in the cursor when cx <= x <= cx+63 and cy <= y <= cy+63, with no wrap at the 12-bit limit.
- R5: A write with `wr_sel`=2 stores `wr_data[15:0]` into shape word `wr_addr[8:0]`. An in-cursor pixel takes its code from word (y-cy)*8 + (x-cx)/8, at bits 2*((x-cx) mod 8)+1 : 2*((x-cx) mod 8).
- R6: Code 0 leaves the color-table color. Codes 1, 2 and 3 output cursor colors 0, 1 and 2. A write with `wr_sel`=1 stores `wr_data` into cursor color `wr_addr[1:0]`, with the same RGB packing as R3. A write with `wr_addr[1:0]`=3 changes nothing.
- R7: While `cfg_cursor_off` is 1 for a pixel, that pixel shows its color-table color whatever the cursor shape and position.
- R8: While `cfg_blank` is 1 for a valid pixel, its output is 0. This overrides the color table and the cursor.
- R9: A write takes effect for pixels presented in the next clock. A pixel presented in the same clock as a write to the entry it uses sees the old value.
- R10: A write with `wr_sel`=3 changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this clock |
| in_index | input | 8 | Pixel color index |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel line |
| cfg_blank | input | 1 | Force black output |
| cfg_cursor_off | input | 1 | Suppress the cursor overlay |
| cur_pos | input | 24 | Cursor position, x in 23:12 and y in 11:0 |
| wr_en | input | 1 | Memory write strobe |
| wr_sel | input | 2 | Write target: 0 color table, 1 cursor colors, 2 cursor shape, 3 none |
| wr_addr | input | 9 | Write entry address |
| wr_data | input | 24 | Write data |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Output color, red in 23:16 |

## Verification
The case that needs the most care is a table write landing in the same clock as a pixel that reads that entry. The bench presents index 7 in the clock that rewrites entry 7, then again in the next clock. It expects the old color first and the new color second. Random runs mix shape, cursor-color and color-table writes into a pixel stream around the cursor edges. A reference model that applies each write only after it has computed that clock's pixel judges every output.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;

    localparam int CHAN_W     = 8;
    localparam int RGB_W      = 3 * CHAN_W;
    localparam int CPAL_DEPTH = 4;
    localparam int CODE_W     = 2;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        WT_COLOR   = 2'd0,
        WT_CURCOL  = 2'd1,
        WT_SHAPE   = 2'd2,
        WT_NONE    = 2'd3
    } wr_target_e;

    localparam rgb_t BLACK = '0;

    function automatic logic code_opaque(input logic [CODE_W-1:0] code);
        return code != '0;
    endfunction

endpackage

// File: rtl/pixmix_table.sv
module pixmix_table #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // combinational read: a same-edge write is not yet visible
    assign rdata = mem[raddr];

endmodule

// File: rtl/pixmix_cursor_locate.sv
module pixmix_cursor_locate #(
    parameter int COORD_W    = 12,
    parameter int CURSOR_DIM = 64,
    parameter int CODES_PW   = 8,
    parameter int DIM_LOG    = $clog2(CURSOR_DIM),
    parameter int CODE_LOG   = $clog2(CODES_PW),
    parameter int WIDX_W     = 2 * DIM_LOG - CODE_LOG
) (
    input  logic [COORD_W-1:0]  x,
    input  logic [COORD_W-1:0]  y,
    input  logic [COORD_W-1:0]  cx,
    input  logic [COORD_W-1:0]  cy,
    output logic                hit,
    output logic [WIDX_W-1:0]   word_idx,
    output logic [CODE_LOG-1:0] sub
);

    localparam logic [COORD_W:0] DIM_V = (COORD_W+1)'(CURSOR_DIM);

    logic [COORD_W:0] dx;
    logic [COORD_W:0] dy;
    logic             in_x;
    logic             in_y;

    always_comb begin
        dx   = {1'b0, x} - {1'b0, cx};
        dy   = {1'b0, y} - {1'b0, cy};
        in_x = (x >= cx) && (dx < DIM_V);
        in_y = (y >= cy) && (dy < DIM_V);
        hit  = in_x && in_y;
        word_idx = {dy[DIM_LOG-1:0], dx[DIM_LOG-1:CODE_LOG]};
        sub      = dx[CODE_LOG-1:0];
    end

endmodule

// File: rtl/pixmix_top.sv
module pixmix_top
    import pixmix_pkg::*;
#(
    parameter int PAL_DEPTH  = 256,
    parameter int COORD_W    = 12,
    parameter int CURSOR_DIM = 64,
    parameter int SHAPE_W    = 16,
    parameter int IDX_W      = $clog2(PAL_DEPTH),
    parameter int CODES_PW   = SHAPE_W / CODE_W,
    parameter int SHAPE_D    = CURSOR_DIM * CURSOR_DIM / CODES_PW,
    parameter int SHAPE_AW   = $clog2(SHAPE_D),
    parameter int WR_AW      = (SHAPE_AW > IDX_W) ? SHAPE_AW : IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IDX_W-1:0]     in_index,
    input  logic [COORD_W-1:0]   in_x,
    input  logic [COORD_W-1:0]   in_y,
    input  logic                 cfg_blank,
    input  logic                 cfg_cursor_off,
    input  logic [2*COORD_W-1:0] cur_pos,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WR_AW-1:0]     wr_addr,
    input  logic [RGB_W-1:0]     wr_data,
    output logic                 out_valid,
    output logic [RGB_W-1:0]     out_rgb
);

    localparam int CODE_LOG = $clog2(CODES_PW);
    localparam int CPAL_AW  = $clog2(CPAL_DEPTH);

    wr_target_e tgt;
    assign tgt = wr_target_e'(wr_sel);

    // ---------------- write steering ----------------
    logic we_color, we_curcol, we_shape;
    always_comb begin
        we_color  = wr_en && (tgt == WT_COLOR);
        we_curcol = wr_en && (tgt == WT_CURCOL)
                    && (wr_addr[CPAL_AW-1:0] != CPAL_AW'(CPAL_DEPTH - 1));
        we_shape  = wr_en && (tgt == WT_SHAPE);
    end

    // ---------------- lookups ----------------
    logic [RGB_W-1:0]    color_rd;
    logic [RGB_W-1:0]    curcol_rd;
    logic [SHAPE_W-1:0]  shape_rd;
    logic                cur_hit;
    logic [SHAPE_AW-1:0] shape_idx;
    logic [CODE_LOG-1:0] code_sub;
    logic [CODE_W-1:0]   code;

    pixmix_table #(.DEPTH(PAL_DEPTH), .WIDTH(RGB_W)) u_color_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (we_color),
        .waddr (wr_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .raddr (in_index),
        .rdata (color_rd)
    );

    pixmix_cursor_locate #(
        .COORD_W    (COORD_W),
        .CURSOR_DIM (CURSOR_DIM),
        .CODES_PW   (CODES_PW)
    ) u_locate (
        .x        (in_x),
        .y        (in_y),
        .cx       (cur_pos[2*COORD_W-1:COORD_W]),
        .cy       (cur_pos[COORD_W-1:0]),
        .hit      (cur_hit),
        .word_idx (shape_idx),
        .sub      (code_sub)
    );

    pixmix_table #(.DEPTH(SHAPE_D), .WIDTH(SHAPE_W)) u_shape_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (we_shape),
        .waddr (wr_addr[SHAPE_AW-1:0]),
        .wdata (wr_data[SHAPE_W-1:0]),
        .raddr (shape_idx),
        .rdata (shape_rd)
    );

    assign code = shape_rd[{code_sub, 1'b0} +: CODE_W];

    pixmix_table #(.DEPTH(CPAL_DEPTH), .WIDTH(RGB_W)) u_curcol_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (we_curcol),
        .waddr (wr_addr[CPAL_AW-1:0]),
        .wdata (wr_data),
        .raddr (code - CODE_W'(1)),
        .rdata (curcol_rd)
    );

    // ---------------- stage 1: lookup results ----------------
    logic s1_valid, s1_blank, s1_show_cur;
    rgb_t s1_base, s1_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid    <= 1'b0;
            s1_blank    <= 1'b0;
            s1_show_cur <= 1'b0;
            s1_base     <= BLACK;
            s1_cur      <= BLACK;
        end else begin
            s1_valid    <= in_valid;
            s1_blank    <= cfg_blank;
            s1_show_cur <= cur_hit && !cfg_cursor_off && code_opaque(code);
            s1_base     <= rgb_t'(color_rd);
            s1_cur      <= rgb_t'(curcol_rd);
        end
    end

    // ---------------- stage 2: select and blank ----------------
    rgb_t mix;
    always_comb begin
        if (!s1_valid || s1_blank) begin
            mix = BLACK;
        end else if (s1_show_cur) begin
            mix = s1_cur;
        end else begin
            mix = s1_base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_rgb   <= mix;
        end
    end

endmodule

// File: rtl/pixmix_checker.sv
module pixmix_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        cfg_blank,
    input logic        out_valid,
    input logic [23:0] out_rgb
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && out_rgb == 24'd0));                               // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));              // R2

    AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_rgb == 24'd0));                                      // R2

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd2) && $past(in_valid && cfg_blank, 2)) |-> (out_rgb == 24'd0)); // R8

endmodule

bind pixmix_top pixmix_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_blank (cfg_blank),
    .out_valid (out_valid),
    .out_rgb   (out_rgb)
);

// File: tb/pixmix_top_bench.sv
`timescale 1ns/1ps
module pixmix_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_index = '0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic        cfg_blank = 1'b0;
    logic        cfg_cursor_off = 1'b0;
    logic [23:0] cur_pos = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    always #2.5 clk = ~clk;

    pixmix_top u_pixmix_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index),
        .in_x(in_x), .in_y(in_y), .cfg_blank(cfg_blank),
        .cfg_cursor_off(cfg_cursor_off), .cur_pos(cur_pos),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // reference state
    int m_col [256];
    int m_cur [3];
    int m_shp [512];

    // stimulus for the next step
    bit d_v, d_blank, d_off, d_we;
    int d_idx, d_x, d_y, d_cx, d_cy, d_sel, d_addr, d_data;

    int q_v[$];
    int q_rgb[$];
    string q_tag[$];
    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    function automatic int ref_pixel();
        int col, dx, dy, w, c;
        if (!d_v || d_blank) return 0;
        col = m_col[d_idx];
        if (!d_off && d_x >= d_cx && d_x < d_cx + 64 && d_y >= d_cy && d_y < d_cy + 64) begin
            dx = d_x - d_cx;
            dy = d_y - d_cy;
            w  = m_shp[dy * 8 + dx / 8];
            c  = (w >> (2 * (dx % 8))) & 3;
            if (c != 0) col = m_cur[c - 1];
        end
        return col;
    endfunction

    task automatic check(input string tag, input int gv, input int ev, input int gr, input int er);
        nchk++;
        if (gv != ev || gr != er) begin
            nfail++;
            $display("FAIL %s: got valid=%0d rgb=%06h expected valid=%0d rgb=%06h", tag, gv, gr, ev, er);
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        if (q_v.size() >= 2) begin
            check(q_tag.pop_front(), int'(out_valid), q_v.pop_front(), int'(out_rgb), q_rgb.pop_front());
        end
        q_v.push_back(d_v ? 1 : 0);
        q_rgb.push_back(ref_pixel());
        q_tag.push_back(tag);
        if (d_we) begin
            case (d_sel)
                0: m_col[d_addr & 255] = d_data & 24'hffffff;
                1: if ((d_addr & 3) != 3) m_cur[d_addr & 3] = d_data & 24'hffffff;
                2: m_shp[d_addr & 511] = d_data & 16'hffff;
                default: ;
            endcase
        end
        in_valid = d_v; in_index = d_idx[7:0]; in_x = d_x[11:0]; in_y = d_y[11:0];
        cfg_blank = d_blank; cfg_cursor_off = d_off;
        cur_pos = {d_cx[11:0], d_cy[11:0]};
        wr_en = d_we; wr_sel = d_sel[1:0]; wr_addr = d_addr[8:0]; wr_data = d_data[23:0];
    endtask

    task automatic idle();
        d_v = 0; d_we = 0;
    endtask

    task automatic wr(input int sel, input int a, input int d, input string tag);
        idle(); d_we = 1; d_sel = sel; d_addr = a; d_data = d;
        step(tag);
        d_we = 0;
    endtask

    task automatic pix(input int idx, input int x, input int y, input string tag);
        d_v = 1; d_idx = idx; d_x = x; d_y = y;
        step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            nchk++; nfail++;
            $display("FAIL R2 watchdog: got cycle=%0d expected completion earlier", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_col[i] = 0;
        for (int i = 0; i < 3; i++) m_cur[i] = 0;
        for (int i = 0; i < 512; i++) m_shp[i] = 0;
        d_v = 0; d_blank = 0; d_off = 0; d_we = 0;
        d_idx = 0; d_x = 0; d_y = 0; d_cx = 0; d_cy = 0; d_sel = 0; d_addr = 0; d_data = 0;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", int'(out_valid), 0, int'(out_rgb), 0);
        rst = 0;
        q_v.push_back(0); q_rgb.push_back(0); q_tag.push_back("R1");
        q_v.push_back(0); q_rgb.push_back(0); q_tag.push_back("R1");
        d_off = 1;
        pix(200, 10, 10, "R1");
        pix(0, 11, 10, "R1");
        idle(); step("R2"); step("R2");

        // R3: load the color table and read it back
        for (int i = 0; i < 256; i++)
            wr(0, i, (i << 16) | ((255 - i) << 8) | (i ^ 8'h5a), "R3");
        for (int i = 0; i < 40; i++) begin
            pix((i * 37 + 3) & 255, i, 300, "R3");
            if (i % 5 == 0) begin idle(); step("R2"); end
        end
        pix(0, 0, 0, "R3");
        pix(255, 4095, 4095, "R3");

        // R6, R5: cursor colors and shape
        wr(1, 0, 24'hff0000, "R6");
        wr(1, 1, 24'h00ff00, "R6");
        wr(1, 2, 24'h0000ff, "R6");
        wr(1, 3, 24'h123456, "R6");
        for (int i = 0; i < 512; i++)
            wr(2, i, (i * 16'h9e37 + 16'h1234) ^ (i << 7), "R5");

        // R4, R5, R6: edges of the cursor window
        d_off = 0; d_cx = 100; d_cy = 50;
        foreach (m_cur[k]) ;
        for (int yi = 0; yi < 6; yi++) begin
            for (int xi = 0; xi < 8; xi++) begin
                int ys[6] = '{49, 50, 51, 112, 113, 114};
                int xs[8] = '{98, 99, 100, 101, 107, 108, 163, 164};
                pix(xi * 31 + yi, xs[xi], ys[yi], "R4");
            end
        end
        for (int dx = 0; dx < 64; dx++) pix(dx, 100 + dx, 77, "R5");

        // R7: same pixels with the cursor off
        d_off = 1;
        for (int dx = 0; dx < 64; dx += 3) pix(dx, 100 + dx, 77, "R7");
        d_off = 0;

        // R8: blank over cursor and table
        d_blank = 1;
        for (int dx = 0; dx < 16; dx++) pix(dx + 9, 100 + dx, 60, "R8");
        d_blank = 0;

        // R9: write in the same clock as a read of that entry
        d_v = 1; d_idx = 7; d_x = 3000; d_y = 3000;
        d_we = 1; d_sel = 0; d_addr = 7; d_data = 24'habcdef;
        step("R9");
        d_we = 0;
        pix(7, 3001, 3000, "R9");
        d_we = 1; d_sel = 2; d_addr = (10 * 8) + 1; d_data = 16'hffff;
        pix(1, 100 + 8, 50 + 10, "R9");
        d_we = 0;
        pix(1, 100 + 8, 50 + 10, "R9");

        // R10: no-target writes
        wr(3, 7, 24'h111111, "R10");
        pix(7, 3002, 3000, "R10");
        wr(3, 200, 24'h222222, "R10");
        pix(200, 3003, 3000, "R10");

        // R4: cursor at the far corner and at the origin
        d_cx = 4080; d_cy = 4090;
        for (int i = 0; i < 16; i++) pix(i, 4080 + i, 4095, "R4");
        pix(1, 4079, 4095, "R4");
        d_cx = 0; d_cy = 0;
        for (int i = 0; i < 16; i++) pix(i, i * 5, 63 - i, "R4");
        pix(1, 64, 0, "R4");
        pix(1, 0, 64, "R4");

        // mixed random run
        d_cx = 200; d_cy = 120;
        for (int n = 0; n < 3000; n++) begin
            d_v = ($urandom % 8) != 0;
            d_idx = $urandom % 256;
            d_x = 190 + ($urandom % 84);
            d_y = 110 + ($urandom % 84);
            d_blank = ($urandom % 16) == 0;
            d_off = ($urandom % 10) == 0;
            d_we = ($urandom % 4) == 0;
            d_sel = $urandom % 4;
            d_addr = $urandom % 512;
            d_data = $urandom;
            step("R9");
        end
        idle(); d_blank = 0; d_off = 0;
        step("R2"); step("R2"); step("R2");
        finish_run();
    end

endmodule